// File: doc/BRIEF.md
# Request-Driven Differential Clock Stop Controller

This block sits between a free-running reference clock and six differential clock lanes, each a true/complement pair with its own drive-enable flag. Two active-low request inputs, fully asynchronous to the reference clock, let downstream consumers ask for their clocks. A deasserted request (input high) stops every lane whose mask bit ties it to that request. An asserted request lets those lanes run again.

Each request input passes through a synchronizer and a two-edge stability filter before it can act. The filtered requests are combined with the per-lane masks, and the result is retimed on the falling edge of the reference clock. The gate therefore only opens or closes while the clock is low, and a lane can never emit a shortened high pulse. A stopped lane is either parked, with true high, complement low and the pair still driven, or released to high impedance, depending on a global drive-mode input. A per-lane enable overrides all of this and floats the pair.

Top module: `diff_clk_stop_ctrl`

## Requirements
- R1: A level change on `req_n_i[r]` takes effect only if the synchronized level stays the same across two consecutive rising edges of `clk_i`. A low pulse that spans only one rising edge has no effect on any lane.
- R2: Bit `stop_mask_i[r*6+k]` ties lane k to request r: bits 5:0 belong to request 0 and bits 11:6 to request 1. A lane stops only while at least one request tied to it is filtered high. A lane with no mask bits set runs at all times.
- R3: A lane tied to both requests runs only while both requests are filtered low.
- R4: With `park_hiz_i` = 0, a stopped lane holds `clk_t_o` = 1, `clk_c_o` = 0 and `drv_en_o` = 1.
- R5: With `park_hiz_i` = 1, a stopped lane holds `clk_t_o` = 0, `clk_c_o` = 0 and `drv_en_o` = 0.
- R6: After a request input falls and stays low, the first rising edge of `clk_t_o` on each lane it released comes 2 to 6 reference periods later.
- R7: All lanes released by the same request falling edge restart on the same rising edge of `clk_i`.
- R8: With `out_en_i[k]` = 0, lane k shows `clk_t_o` = 0, `clk_c_o` = 0 and `drv_en_o` = 0 from the next falling edge on, whatever the request state and drive mode.
- R9: A running, enabled lane has `clk_t_o` equal to `clk_i`, `clk_c_o` equal to its inverse and `drv_en_o` = 1. Gating only changes at falling edges of `clk_i`.
- R10: While `rst_ni` is low, every lane shows `drv_en_o` = 0, `clk_t_o` = 0 and `clk_c_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_n_i | input | 2 | Asynchronous active-low clock requests |
| stop_mask_i | input | 12 | Per-lane stop masks, 6 bits for each request |
| park_hiz_i | input | 1 | Stopped-lane style: 0 parks driven, 1 floats |
| out_en_i | input | 6 | Per-lane master enable |
| clk_t_o | output | 6 | True level of each lane |
| clk_c_o | output | 6 | Complement level of each lane |
| drv_en_o | output | 6 | Drive-enable flag of each lane |

## Verification
A filter stuck at one value, or one that counts a single edge as stable, shows up within about five reference periods. Lanes then keep running while they should be parked, or a one-edge glitch stops them. A wrong mask decode or a wrong park level shows in the first phase sample after the gate retimes: a lane has the wrong level in its high or low phase, or the wrong drive flag. Resume latency and the common restart edge are measured edge by edge after each request falls. An extra or missing pipeline stage therefore moves the first true-line rising edge outside the 2-to-6 window, or splits it across lanes.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic {
    STOP_PARK = 1'b0,
    STOP_HIZ  = 1'b1
  } stop_style_e;

  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/dcs_req_filter.sv
module dcs_req_filter
  import dcs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_n_i,
  output logic req_n_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hold_q;
  logic                   filt_q;
  logic                   sync_out;

  assign sync_out = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      hold_q <= 1'b1;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], req_n_i};
      hold_q <= sync_out;
      // accept only a level seen on two consecutive edges
      if (sync_out == hold_q) filt_q <= sync_out;
    end
  end

  assign req_n_o = filt_q;
endmodule

// File: rtl/dcs_stop_map.sv
module dcs_stop_map #(
  parameter int unsigned NUM_OUT = 6,
  parameter int unsigned NUM_REQ = 2,
  localparam int unsigned MASK_W = NUM_OUT * NUM_REQ
) (
  input  logic [NUM_REQ-1:0] req_n_i,
  input  logic [MASK_W-1:0]  mask_i,
  output logic [NUM_OUT-1:0] stop_o
);
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_lane
    logic [NUM_REQ-1:0] hit;
    for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
      assign hit[r] = req_n_i[r] & mask_i[r*NUM_OUT+k];
    end
    assign stop_o[k] = |hit;
  end
endmodule

// File: rtl/dcs_lane_gate.sv
module dcs_lane_gate
  import dcs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  input  logic en_i,
  input  logic hiz_i,
  output logic clk_t_o,
  output logic clk_c_o,
  output logic drv_en_o,
  output logic run_o
);
  logic        run_q;
  logic        en_q;
  stop_style_e style_q;

  // retime on the falling edge so the gate moves only while clk is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      en_q    <= 1'b0;
      style_q <= STOP_HIZ;
    end else begin
      run_q   <= ~stop_i;
      en_q    <= en_i;
      style_q <= stop_style_e'(hiz_i);
    end
  end

  always_comb begin
    clk_t_o  = 1'b0;
    clk_c_o  = 1'b0;
    drv_en_o = 1'b0;
    if (en_q) begin
      if (run_q) begin
        clk_t_o  = clk_i;
        clk_c_o  = ~clk_i;
        drv_en_o = 1'b1;
      end else if (style_q == STOP_PARK) begin
        clk_t_o  = 1'b1;
        drv_en_o = 1'b1;
      end
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/diff_clk_stop_ctrl.sv
module diff_clk_stop_ctrl #(
  parameter int unsigned NUM_OUT = 6,
  parameter int unsigned NUM_REQ = 2,
  localparam int unsigned MASK_W = NUM_OUT * NUM_REQ
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_n_i,
  input  logic [MASK_W-1:0]  stop_mask_i,
  input  logic               park_hiz_i,
  input  logic [NUM_OUT-1:0] out_en_i,
  output logic [NUM_OUT-1:0] clk_t_o,
  output logic [NUM_OUT-1:0] clk_c_o,
  output logic [NUM_OUT-1:0] drv_en_o
);
  logic [NUM_REQ-1:0] req_filt;
  logic [NUM_OUT-1:0] lane_stop;
  logic [NUM_OUT-1:0] lane_run;

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_filt
    dcs_req_filter u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_n_i(req_n_i[r]),
      .req_n_o(req_filt[r])
    );
  end

  dcs_stop_map #(
    .NUM_OUT(NUM_OUT),
    .NUM_REQ(NUM_REQ)
  ) u_map (
    .req_n_i(req_filt),
    .mask_i (stop_mask_i),
    .stop_o (lane_stop)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_lane
    dcs_lane_gate u_gate (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .stop_i  (lane_stop[k]),
      .en_i    (out_en_i[k]),
      .hiz_i   (park_hiz_i),
      .clk_t_o (clk_t_o[k]),
      .clk_c_o (clk_c_o[k]),
      .drv_en_o(drv_en_o[k]),
      .run_o   (lane_run[k])
    );
  end
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
  parameter int unsigned NUM_OUT = 6,
  parameter int unsigned NUM_REQ = 2,
  localparam int unsigned MASK_W = NUM_OUT * NUM_REQ
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_REQ-1:0] req_n_i,
  input logic [MASK_W-1:0]  stop_mask_i,
  input logic [NUM_OUT-1:0] clk_t_o,
  input logic [NUM_OUT-1:0] clk_c_o,
  input logic [NUM_OUT-1:0] drv_en_o,
  input logic [NUM_REQ-1:0] req_filt_i,
  input logic [NUM_OUT-1:0] run_i
);
  for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
    assert_debounce_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(req_filt_i[r]) |->
        ($past(req_n_i[r], 3) == req_filt_i[r]) && ($past(req_n_i[r], 4) == req_filt_i[r]));
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_lane
    logic [NUM_REQ-1:0] tie;
    for (genvar r = 0; r < NUM_REQ; r++) begin : g_tie
      assign tie[r] = stop_mask_i[r*NUM_OUT+k];
    end

    assert_stop_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(run_i[k]) |-> |(tie & req_filt_i));

    assert_both_tied_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i[k] && (&tie)) |-> (req_filt_i == '0));

    assert_pair_opposite_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drv_en_o[k] |-> (clk_t_o[k] != clk_c_o[k]));

    assert_float_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !drv_en_o[k] |-> (!clk_t_o[k] && !clk_c_o[k]));
  end
endmodule

bind diff_clk_stop_ctrl dcs_checker #(
  .NUM_OUT(NUM_OUT),
  .NUM_REQ(NUM_REQ)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_n_i    (req_n_i),
  .stop_mask_i(stop_mask_i),
  .clk_t_o    (clk_t_o),
  .clk_c_o    (clk_c_o),
  .drv_en_o   (drv_en_o),
  .req_filt_i (req_filt),
  .run_i      (lane_run)
);

// File: tb/sim_diff_clk_stop_ctrl.sv
`timescale 1ns/1ps
module sim_diff_clk_stop_ctrl;
  localparam int NO = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    req_n = 2'b11;
  logic [2*NO-1:0] mask = '0;
  logic          hiz = 1'b1;
  logic [NO-1:0] oen = '1;
  logic [NO-1:0] t_o, c_o, d_o;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  diff_clk_stop_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_n_i(req_n), .stop_mask_i(mask),
    .park_hiz_i(hiz), .out_en_i(oen), .clk_t_o(t_o), .clk_c_o(c_o), .drv_en_o(d_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic at_hi(); @(posedge clk); #3; endtask
  task automatic at_lo(); @(negedge clk); #3; endtask
  task automatic drv_req(input logic [1:0] v); @(posedge clk); #2; req_n = v; endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) @(posedge clk); endtask

  // sample every lane in one phase against the arithmetic expectation
  task automatic check_phase(input bit hi, input logic [NO-1:0] run, input logic [NO-1:0] en,
                             input bit mode, input logic [NO-1:0] both);
    for (int k = 0; k < NO; k++) begin
      logic et, ec, ed;
      string tag;
      if (!en[k]) begin et = 0; ec = 0; ed = 0; tag = "R8"; end
      else if (run[k]) begin et = hi; ec = !hi; ed = 1; tag = both[k] ? "R3" : "R9"; end
      else if (mode) begin et = 0; ec = 0; ed = 0; tag = both[k] ? "R3" : "R5"; end
      else begin et = 1; ec = 0; ed = 1; tag = both[k] ? "R3" : "R4"; end
      chk($sformatf("%s lane%0d t", tag, k), {7'd0, t_o[k]}, {7'd0, et});
      chk($sformatf("%s lane%0d c", tag, k), {7'd0, c_o[k]}, {7'd0, ec});
      chk($sformatf("%s lane%0d drv", tag, k), {7'd0, d_o[k]}, {7'd0, ed});
    end
  endtask

  initial begin
    #10_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #22;
    // R10 reset state
    for (int k = 0; k < NO; k++) begin
      chk($sformatf("R10 lane%0d drv", k), {7'd0, d_o[k]}, 8'd0);
      chk($sformatf("R10 lane%0d t", k), {7'd0, t_o[k]}, 8'd0);
      chk($sformatf("R10 lane%0d c", k), {7'd0, c_o[k]}, 8'd0);
    end
    rst_n = 1'b1;
    idle(3);

    // R2/R3/R4/R5/R9 sweep: every request state x every mask code, both styles
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 4; p++) begin
        logic [NO-1:0] m0, m1;
        for (int k = 0; k < NO; k++) begin
          int code = (k + p) % 4;
          m0[k] = code[0];
          m1[k] = code[1];
        end
        @(posedge clk); #2; hiz = m[0]; mask = {m1, m0};
        for (int s = 0; s < 4; s++) begin
          logic [1:0] sv = 2'(s);
          logic [NO-1:0] run;
          drv_req(sv);
          idle(8);
          for (int k = 0; k < NO; k++)
            run[k] = !((m0[k] & sv[0]) | (m1[k] & sv[1]));
          at_hi(); check_phase(1, run, oen, m[0], m0 & m1);
          at_lo(); check_phase(0, run, oen, m[0], m0 & m1);
        end
      end
    end

    // R6/R7 resume latency and common restart edge
    @(posedge clk); #2; hiz = 0; mask = {{NO{1'b0}}, {NO{1'b1}}}; req_n = 2'b11;
    idle(8);
    begin
      int first [NO];
      for (int k = 0; k < NO; k++) first[k] = 0;
      drv_req(2'b10);
      for (int i = 1; i <= 8; i++) begin
        at_lo();
        for (int k = 0; k < NO; k++) if (t_o[k] == 1'b0 && first[k] == 0) first[k] = -1;
        at_hi();
        for (int k = 0; k < NO; k++) if (t_o[k] == 1'b1 && first[k] == -1) first[k] = i;
      end
      for (int k = 0; k < NO; k++) begin
        chk($sformatf("R6 lane%0d latency in 2..6", k),
            {7'd0, (first[k] >= 2 && first[k] <= 6)}, 8'd1);
        chk($sformatf("R7 lane%0d same edge", k), 8'(first[k]), 8'(first[0]));
      end
    end

    // R1 one-edge pulse ignored, two-edge pulse accepted
    drv_req(2'b11);
    idle(8);
    drv_req(2'b10);
    drv_req(2'b11);
    begin
      int low_seen = 0;
      for (int i = 0; i < 10; i++) begin
        at_lo(); if (t_o[0] == 1'b0) low_seen++;
      end
      chk("R1 short pulse ignored", 8'(low_seen), 8'd0);
      drv_req(2'b10);
      @(posedge clk); #2; req_n = 2'b10;
      drv_req(2'b11);
      low_seen = 0;
      for (int i = 0; i < 10; i++) begin
        at_lo(); if (t_o[0] == 1'b0) low_seen++;
      end
      chk("R1 two-edge pulse accepted", {7'd0, low_seen > 0}, 8'd1);
    end

    // R8 enable override while running and while parked
    @(posedge clk); #2; mask = '0; oen = 6'b111011;
    idle(3);
    at_hi(); check_phase(1, '1, oen, 0, '0);
    at_lo(); check_phase(0, '1, oen, 0, '0);
    @(posedge clk); #2; mask = {{NO{1'b0}}, {NO{1'b1}}}; oen = 6'b011111;
    idle(8);
    at_hi(); check_phase(1, '0, oen, 0, '0);
    at_lo(); check_phase(0, '0, oen, 0, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule